// File: doc/BRIEF.md
# Two-Level Write Protection Controller

This block decides, one byte at a time, whether a write to a 256-byte nonvolatile array may commit. It combines two protection sources. The first is a one-time software lock that covers the lower half of the array. The second is an external protect pin that covers the whole array. It also times the internal programming cycle. A busy output stays high for a fixed number of clocks after each write cycle starts, and this holds whether the bytes were committed or blocked.

The serial front end drives the block. That front end presents each received data byte with its array address on `wr_req`/`wr_addr` and uses `commit_en` to gate the cell write. It pulses `cyc_start` when a write command ends, and pulses `set_req` when it receives the lock command. It consults `lock_ack_en` to decide whether to acknowledge that command. The lock flag models nonvolatile state. Power-on reset loads it from a parameter, and no input can clear it afterwards.

Top module: `wp_ctrl`

## Requirements
- R1: With the lock flag set and the pin low, a write whose address has bit 7 clear (00h–7Fh) gets `commit_en`=0, and a write whose address has bit 7 set (80h–FFh) gets `commit_en`=1.
- R2: Power-on reset loads the lock flag from `LOCK_INIT`. Once the flag is set, no combination of `set_req`, `wp_pin`, `wr_req` or `cyc_start` clears it.
- R3: While `wp_pin` is 1, `commit_en` is 0 for every address, whatever the state of the lock flag.
- R4: A `set_req` pulse seen while `wp_pin` is 1 leaves the flag clear. Afterwards `lock_ack_en` is still 1, and a lower-half write still commits once the pin is low.
- R5: With the pin low and the flag clear, every address commits (`commit_en`=`wr_req`).
- R6: A `cyc_start` pulse seen while idle raises `busy` on the next clock. `busy` stays high for exactly `WCYC` clocks, and this holds whether the write was blocked or committed.
- R7: While `busy` is 1, `commit_en` and `lock_ack_en` are 0, and `set_req` and `cyc_start` are ignored.
- R8: A `set_req` seen while idle with the pin low sets the flag on that clock edge. From the next cycle on, `lock_ack_en` is 0.
- R9: The decision is made per byte. A run of writes to 7Eh, 7Fh, 80h, 81h under the software lock yields 0, 0, 1, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wp_pin | input | 1 | External protect level (1 protects the whole array) |
| set_req | input | 1 | Request to set the one-time lower-half lock |
| wr_req | input | 1 | Byte write request |
| wr_addr | input | 8 | Byte address of the write request |
| cyc_start | input | 1 | Starts the timed write cycle |
| commit_en | output | 1 | The current byte may be written to the array |
| lock_ack_en | output | 1 | The lock command may be acknowledged |
| busy | output | 1 | The write cycle is in progress |

## Verification
The assertions check, on every cycle, the behaviours that hold at each step. The pin blocks every commit. The lock blocks lower-half commits. The flag never clears, and it cannot set while the pin is high. A busy cycle masks commits and the lock acknowledge. Every busy period lasts exactly `WCYC` clocks. Only the bench scenarios can show the ordering effects. These include a refused lock request that leaves later lower-half writes committing, a lock request ignored during busy, and the per-byte result across the 7Fh/80h boundary.

// File: rtl/wp_ctrl.sv
module wp_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int WCYC      = 100,
  parameter bit LOCK_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              set_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              cyc_start,
  output logic              commit_en,
  output logic              lock_ack_en,
  output logic              busy
);
  localparam int CW = $clog2(WCYC + 1);

  logic          sw_lock;
  logic [CW-1:0] cnt;
  logic          low_half;

  assign busy        = (cnt != '0);
  assign low_half    = ~wr_addr[ADDR_W-1];
  assign commit_en   = wr_req & ~busy & ~wp_pin & ~(sw_lock & low_half);
  assign lock_ack_en = ~sw_lock & ~busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      sw_lock <= LOCK_INIT;
    else if (set_req && lock_ack_en && !wp_pin)
      sw_lock <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt <= '0;
    else if (cyc_start && !busy)
      cnt <= CW'(WCYC);
    else if (busy)
      cnt <= cnt - 1'b1;
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int WCYC   = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_pin,
  input logic              cyc_start,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              commit_en,
  input logic              lock_ack_en,
  input logic              busy,
  input logic              sw_lock
);
  int unsigned bcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;

  AST_PIN_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    wp_pin |-> !commit_en); // R3
  AST_LOCK_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_lock && !wr_addr[ADDR_W-1]) |-> !commit_en); // R1
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_lock |=> sw_lock); // R2
  AST_PIN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pin && !sw_lock) |=> !sw_lock); // R4
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!commit_en && !lock_ack_en)); // R7
  AST_NO_ACK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    sw_lock |-> !lock_ack_en); // R8
  AST_CYCLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !busy) |=> busy); // R6
  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == WCYC)); // R6
endmodule

bind wp_ctrl wp_ctrl_chk #(.ADDR_W(ADDR_W), .WCYC(WCYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .cyc_start(cyc_start),
  .wr_addr(wr_addr), .commit_en(commit_en), .lock_ack_en(lock_ack_en),
  .busy(busy), .sw_lock(sw_lock)
);

// File: tb/tb_wp_ctrl.sv
module tb_wp_ctrl;
  localparam int WCYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_pin = 1'b0, set_req = 1'b0, wr_req = 1'b0, cyc_start = 1'b0;
  logic [7:0] wr_addr = '0;
  logic       commit_en, lock_ack_en, busy;

  int nchk = 0, nfail = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  wp_ctrl #(.ADDR_W(8), .WCYC(WCYC), .LOCK_INIT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .set_req(set_req),
    .wr_req(wr_req), .wr_addr(wr_addr), .cyc_start(cyc_start),
    .commit_en(commit_en), .lock_ack_en(lock_ack_en), .busy(busy)
  );

  task automatic check(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (wr_req && exp_q.size() > 0) begin
      automatic bit    e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, commit_en, e);
    end

  task automatic wr(string req, logic [7:0] a, bit exp);
    @(posedge clk); #1;
    wr_req = 1'b1; wr_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(posedge clk); #1;
    wr_req = 1'b0;
  endtask

  task automatic pulse_set();
    @(posedge clk); #1 set_req = 1'b1;
    @(posedge clk); #1 set_req = 1'b0;
  endtask

  task automatic run_cycle(string req);
    int n = 0;
    @(posedge clk); #1 cyc_start = 1'b1;
    @(posedge clk); #1 cyc_start = 1'b0;
    @(negedge clk);
    while (busy && n < 4 * WCYC) begin
      n++;
      @(negedge clk);
    end
    nchk++;
    if (n != WCYC) begin
      nfail++;
      $display("FAIL %s: busy length actual %0d expected %0d", req, n, WCYC);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("reset busy", busy, 1'b0);
    check("reset R8 ack", lock_ack_en, 1'b1);
    check("reset commit", commit_en, 1'b0);

    // R5: open array
    wr("R5", 8'h00, 1); wr("R5", 8'h7F, 1); wr("R5", 8'h80, 1); wr("R5", 8'hFF, 1);

    // R3: pin protects everything
    @(posedge clk); #1 wp_pin = 1'b1;
    wr("R3", 8'h00, 0); wr("R3", 8'h55, 0); wr("R3", 8'hC3, 0); wr("R3", 8'hFF, 0);

    // R4: lock request refused under the pin
    pulse_set();
    @(posedge clk); #1 wp_pin = 1'b0;
    @(negedge clk);
    check("R4 ack still on", lock_ack_en, 1'b1);
    wr("R4", 8'h10, 1);

    // R6: blocked and committed cycles both take WCYC
    @(posedge clk); #1 wp_pin = 1'b1;
    run_cycle("R6 blocked");
    @(posedge clk); #1 wp_pin = 1'b0;
    run_cycle("R6 committed");

    // R7: quiet while busy
    @(posedge clk); #1 cyc_start = 1'b1;
    @(posedge clk); #1 cyc_start = 1'b0; set_req = 1'b1; wr_req = 1'b1; wr_addr = 8'h90;
    @(negedge clk);
    check("R7 commit", commit_en, 1'b0);
    check("R7 ack", lock_ack_en, 1'b0);
    @(posedge clk); #1 set_req = 1'b0; wr_req = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R7 set ignored", lock_ack_en, 1'b1);
    wr("R7 set ignored", 8'h20, 1);

    // R8: lock set
    pulse_set();
    @(negedge clk);
    check("R8", lock_ack_en, 1'b0);

    // R1: lower half locked
    wr("R1", 8'h00, 0); wr("R1", 8'h7F, 0); wr("R1", 8'h80, 1); wr("R1", 8'hFF, 1);

    // R9: per byte across boundary
    wr("R9", 8'h7E, 0); wr("R9", 8'h7F, 0); wr("R9", 8'h80, 1); wr("R9", 8'h81, 1);

    // R2: nothing clears the lock
    @(posedge clk); #1 wp_pin = 1'b1;
    pulse_set();
    run_cycle("R2 cycle");
    @(posedge clk); #1 wp_pin = 1'b0;
    pulse_set();
    @(negedge clk);
    check("R2 ack", lock_ack_en, 1'b0);
    wr("R2", 8'h05, 0);
    wr("R2", 8'hA5, 1);

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule